// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets software reach the management registers of an Ethernet PHY through two 32-bit registers on a plain register bus. The first is a command register. The second is a data register. Software first stages any value to be written in the data register. It then writes the command register with the PHY address, the PHY register index and the direction, with the busy bit set. The block then sends one clause 22 MDIO frame on the MDC/MDIO pins, and it clears busy when the frame ends. After a read, the 16-bit value returned by the PHY sits in the data register.

MDC is produced from the system clock by a divider parameter. MDC only toggles while a frame is in progress. The MDIO pin is split into an output value, an output enable and an input. The enable is dropped whenever the PHY is meant to drive the line, so a tri-state pad can be placed at chip level.

Top module: `mdio_bridge`

## Requirements
- R1: The command register is at byte offset 0x0. It holds the PHY address in bits 15:11, the PHY register index in bits 10:6, the direction in bit 1 (1 = write, 0 = read) and busy in bit 0. All other bits read as zero. A read returns the fields last accepted.
- R2: A write to the command register with bit 0 set, while busy is clear, starts a frame. Busy reads as 1 from the next bus access onward.
- R3: A write to the command register with bit 0 clear, while busy is clear, stores the fields and starts no frame. MDC stays low and busy stays 0.
- R4: A write to the command register while busy is set is ignored entirely. The running frame, the stored fields and the number of frames are all unchanged.
- R5: Each frame is 64 MDC cycles, sent most significant bit first. It is made of 32 ones, then 01, then the opcode (01 for write, 10 for read), the 5-bit PHY address, the 5-bit register index, then for a write the turnaround 10 and the 16 bits of the data register.
- R6: During a read, the MDIO output enable is low for the two turnaround bits and the 16 data bits (bit slots 46 to 63). It is high for slots 0 to 45.
- R7: During a read, MDIO is sampled on each rising MDC edge in slots 48 to 63. Those 16 bits, first sample as the MSB, land in the data register bits 15:0 when busy clears. Bits 31:16 read as zero.
- R8: MDC has a period of 2*DIV_HALF system clocks while a frame runs. It rests low when idle. Busy clears on its own after the frame.
- R9: The data register is at byte offset 0x4. A written value reads back in bits 15:0. Register reads return data one clock after the read strobe.
- R10: The MDIO output enable is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after bus_re |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with DIV_HALF set to 2. At that setting a frame lasts only 256 system clocks, which makes a full sweep affordable. The sweep covers all 32 PHY addresses with a write frame and a read frame each, and each frame uses a different register index and data pattern. A bus-functional PHY in the bench captures every bit on rising MDC and records the output enable alongside it. It answers reads with a pattern derived from the PHY address. The short divider also keeps the busy window small enough to aim command writes squarely inside it, and it lets the MDC period be measured exactly against 2*DIV_HALF.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 64;
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam int SLOT_W     = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regi;
    logic             wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(DIV_HALF - 1));
  assign rise_tk = en && wrap && !mdc;
  assign fall_tk = en && wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic [FRAME_BITS-1:0] shreg;
  logic [SLOT_W-1:0]     slot;
  logic                  is_rd;
  logic [FRAME_BITS-1:0] frame;
  logic [SLOT_W-1:0]     slot_nx;

  always_comb begin
    frame = {{32{1'b1}}, 2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.regi,
             2'b10, (cmd.wr ? wdata : {DATA_W{1'b1}})};
    slot_nx = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      slot    <= '0;
      is_rd   <= 1'b0;
      active  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        shreg   <= frame;
        slot    <= '0;
        is_rd   <= !cmd.wr;
        active  <= 1'b1;
        mdio_o  <= frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end else if (active) begin
        if (rise_tk && is_rd && (int'(slot) >= DATA_SLOT))
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall_tk) begin
          if (slot == SLOT_W'(FRAME_BITS - 1)) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            done    <= 1'b1;
          end else begin
            slot    <= slot_nx;
            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            mdio_o  <= shreg[FRAME_BITS-2];
            mdio_oe <= !(is_rd && (int'(slot_nx) >= TA_SLOT));
          end
        end
      end
    end
  end

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    active && is_rd && (int'(slot) >= TA_SLOT) |-> !mdio_oe);
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !mdio_oe);
  // R5
  wr_driven_chk: assert property (@(posedge clk) disable iff (rst)
    active && !is_rd |-> mdio_oe);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output logic              start,
  output mdio_cmd_t         start_cmd,
  output logic [DATA_W-1:0] data_q,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);
  localparam int PHY_LSB = 11;
  localparam int REG_LSB = 6;

  mdio_cmd_t cmd_q;
  logic      cmd_wr_ok;

  always_comb begin
    cmd_wr_ok       = bus_we && (bus_addr == CMD_OFS) && !busy;
    start           = cmd_wr_ok && bus_wdata[0];
    start_cmd.phy   = bus_wdata[PHY_LSB +: PHY_W];
    start_cmd.regi  = bus_wdata[REG_LSB +: REG_W];
    start_cmd.wr    = bus_wdata[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      busy      <= 1'b0;
      data_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (cmd_wr_ok) begin
        cmd_q <= start_cmd;
        busy  <= bus_wdata[0];
      end
      if (bus_we && (bus_addr == DATA_OFS))
        data_q <= bus_wdata[DATA_W-1:0];
      if (done) begin
        busy <= 1'b0;
        if (!cmd_q.wr) data_q <= rdata;
      end
      if (bus_re) begin
        if (bus_addr == CMD_OFS)
          bus_rdata <= {16'b0, cmd_q.phy, cmd_q.regi, 4'b0, cmd_q.wr, busy};
        else if (bus_addr == DATA_OFS)
          bus_rdata <= {{(32-DATA_W){1'b0}}, data_q};
        else
          bus_rdata <= '0;
      end
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy && $stable(cmd_q));
endmodule

// File: rtl/mdio_bridge.sv
module mdio_bridge
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_HALF = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              start, busy, done, active, rise_tk, fall_tk;
  mdio_cmd_t         start_cmd;
  logic [DATA_W-1:0] data_q, rdata;

  mdio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .done(done), .rdata(rdata), .start(start), .start_cmd(start_cmd),
    .data_q(data_q), .busy(busy)
  );

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .en(active), .mdc(mdc),
    .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_shift_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .cmd(start_cmd), .wdata(data_q),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rdata(rdata)
  );

  // R8
  active_busy_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> busy);
endmodule

// File: tb/test_mdio_bridge.sv
module test_mdio_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0, fails = 0;
  int rise_cnt = 0, base = 0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] resp = '0;
  time last_rise = 0, period = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_bridge #(.ADDR_W(4), .DIV_HALF(DIV)) i_mdio_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  always @(posedge mdc) begin
    cap      <= {cap[62:0], mdio_o};
    oecap    <= {oecap[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
    if (last_rise != 0) period <= $time - last_rise;
    last_rise <= $time;
  end
  always @(negedge mdc) begin
    int idx;
    idx = rise_cnt - base;
    mdio_i <= (idx >= 48 && idx <= 63) ? resp[63-idx] : 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(4'h0, v);
      if (!v[0]) return;
    end
    chk("R8 busy clears", 1, 0);
  endtask

  function automatic logic [31:0] cmdw(input logic [4:0] p, input logic [4:0] r,
                                       input logic w, input logic b);
    return {16'b0, p, r, 4'b0, w, b};
  endfunction

  initial begin
    logic [31:0] v;
    logic [15:0] d;
    logic [4:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(4'h0, v); chk("R1 reset cmd", v, 0);
    rd(4'h4, v); chk("R9 reset data", v, 0);
    chk("R10 reset oe", mdio_oe, 0);
    chk("R8 reset mdc", mdc, 0);
    // R9 data register readback
    wr(4'h4, 32'hFFFF_BEEF);
    rd(4'h4, v); chk("R9 data readback", v, 32'h0000_BEEF);
    // R3 store without start
    base = rise_cnt;
    wr(4'h0, cmdw(5'd19, 5'd7, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    chk("R3 no mdc", rise_cnt - base, 0);
    rd(4'h0, v); chk("R1 R3 fields", v, cmdw(5'd19, 5'd7, 1'b1, 1'b0));
    // sweep
    for (int a = 0; a < 32; a++) begin
      r = 5'(31 - a);
      d = 16'hA5C3 ^ 16'(a * 16'h0811);
      wr(4'h4, {16'h0, d});
      base = rise_cnt;
      wr(4'h0, cmdw(5'(a), r, 1'b1, 1'b1));
      rd(4'h0, v); chk("R2 busy set", v, cmdw(5'(a), r, 1'b1, 1'b1));
      chk("R6 oe during write", mdio_oe, 1);
      wait_idle();
      chk("R5 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(a), r, 2'b10, d});
      chk("R5 write oe", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R8 frame length", rise_cnt - base, 64);
      chk("R8 mdc period", period, 2 * DIV * CLK_PERIOD);
      chk("R10 idle oe", mdio_oe, 0);
      // read
      resp = ~d ^ 16'(a << 3);
      base = rise_cnt;
      wr(4'h0, cmdw(5'(a), 5'(a), 1'b0, 1'b1));
      wait_idle();
      chk("R5 read header", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(a), 5'(a)});
      chk("R6 read oe", oecap, {46'h3FFF_FFFF_FFFF, 18'h0});
      rd(4'h4, v); chk("R7 read data", v, {16'h0, resp});
      rd(4'h0, v); chk("R1 cmd after read", v, cmdw(5'(a), 5'(a), 1'b0, 1'b0));
    end
    // R4 ignore while busy
    wr(4'h4, 32'h0000_1234);
    base = rise_cnt;
    wr(4'h0, cmdw(5'd5, 5'd2, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    wr(4'h0, cmdw(5'd9, 5'd3, 1'b0, 1'b1));
    rd(4'h0, v); chk("R4 fields held", v, cmdw(5'd5, 5'd2, 1'b1, 1'b1));
    wait_idle();
    repeat (400) @(negedge clk);
    chk("R4 single frame", rise_cnt - base, 64);
    chk("R4 frame intact", cap, {32'hFFFF_FFFF, 4'b0101, 5'd5, 5'd2, 2'b10, 16'h1234});
    rd(4'h4, v); chk("R4 data intact", v, 32'h1234);
    chk("R8 idle mdc", mdc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule